// File: doc/BRIEF.md
# Four-Slot Header Record Buffer

This block decouples a header field extractor from a look-up engine. It keeps four header records, each made of 32 words of 16 bits, in a two-port store. A writer can fill one record while the reader works through another, and neither one disturbs the other. Each slot has one occupancy bit. The bit is 0 while the slot is free or being filled. It becomes 1 only when the final word of a record has been accepted. The bit returns to 0 when the reader hands the slot back. A packet identifier travels with every record. The writer supplies it on the final word, and the reader sees it when the slot is offered.

The writer side is a valid/ready stream of words. The writer supplies the word index and marks the final word with `wr_last`. `wr_ready` drops only when no slot is free and no record is in progress, and the writer must hold its beat until `wr_ready` is high. Once a record has started, its slot stays locked to that record until the final word. The reader side offers a completed slot through a valid/ready handshake. After the reader accepts the slot, it reads words by index with a one-cycle read latency and ends its claim with a one-cycle `rd_release` pulse. While the reader holds a slot, no other slot is offered.

Top module: `hdr_slot_buf`

## Requirements
- R1: After reset, all slots are free: `buf_empty`=1, `buf_full`=0, `wr_ready`=1, `rd_valid`=0, `proto_err`=0 and `wr_slot`=0.
- R2: When a new record begins, it goes to the lowest-numbered free slot. `wr_slot` shows the slot that the current beat lands in.
- R3: A slot's occupancy bit rises in the cycle after the final word (`wr_last`=1) is accepted, and never earlier. No slot is offered to the reader while its record is only partly written.
- R4: When all four slots are occupied, `wr_ready` is 0 and no word is accepted.
- R5: The reader is offered occupied slots in round-robin order, starting one past the slot it last released. Slot 0 comes first after reset. No offer is made while a slot is held.
- R6: A read with `rd_en`=1 and word index `rd_addr` on the held slot returns that slot's stored word on `rd_data` in the next cycle. This holds even while the writer is filling another slot in the same cycles.
- R7: `rd_pkt_id` equals the identifier given with the final word of the offered slot's record.
- R8: A `rd_release` pulse while a slot is held clears that slot's bit in the next cycle. The slot can then be reused by the writer.
- R9: `buf_full` is 1 exactly when all four bits are set. `buf_empty` is 1 exactly when none is set. The two are never 1 together.
- R10: A `rd_release` pulse while no slot is held changes no bit and raises `proto_err` for one cycle, in the cycle after the pulse. A set and a clear of the same slot in one cycle also raise `proto_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Writer word valid |
| wr_ready | output | 1 | Writer word accepted when high with wr_valid |
| wr_addr | input | 5 | Word index within the record |
| wr_data | input | 16 | Word value |
| wr_last | input | 1 | Marks the final word of a record |
| wr_pkt_id | input | 12 | Packet identifier, taken with the final word |
| wr_slot | output | 2 | Slot the current write beat lands in |
| rd_valid | output | 1 | A completed slot is offered |
| rd_ready | input | 1 | Reader claims the offered slot |
| rd_slot | output | 2 | Offered slot number |
| rd_pkt_id | output | 12 | Identifier of the offered record |
| rd_en | input | 1 | Read strobe on the held slot |
| rd_addr | input | 5 | Word index to read |
| rd_data | output | 16 | Word read, one cycle after rd_en |
| rd_release | input | 1 | One-cycle pulse that frees the held slot |
| buf_full | output | 1 | All slots occupied |
| buf_empty | output | 1 | No slot occupied |
| proto_err | output | 1 | Protocol misuse seen in the previous cycle |

## Verification
The bench first fills the slots one after another from an empty buffer. This shows that slots are taken lowest first and that no slot is offered before the final word. It then reaches the all-occupied case, where the writer must stall. Next, one slot is freed and refilled while the reader is reading from another slot. This pattern separates a true two-port store from a shared one. It also shows whether round-robin order continues past the slot last served or falls back to slot 0. A stray release on an empty buffer separates a correctly flagged misuse from one that silently changes the occupancy bits.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int unsigned HB_SLOTS_DEF = 4;
  localparam int unsigned HB_REGS_DEF  = 32;
  localparam int unsigned HB_WORD_DEF  = 16;
  localparam int unsigned HB_ID_DEF    = 12;
endpackage

// File: rtl/hb_dpram.sv
module hb_dpram #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned W     = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // Independent write port
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Independent registered read port
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/hb_slot_pick.sv
module hb_slot_pick #(
  parameter int unsigned N = 4,
  localparam int unsigned SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  free_vec,
  input  logic [N-1:0]  full_vec,
  input  logic [SW-1:0] last_idx,
  output logic [SW-1:0] lf_idx,
  output logic          lf_any,
  output logic [SW-1:0] rr_idx,
  output logic          rr_any
);
  // Lowest-numbered free slot: scan downward so the lowest hit is kept
  always_comb begin
    lf_any = 1'b0;
    lf_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) begin
        lf_any = 1'b1;
        lf_idx = SW'(i);
      end
    end
  end

  // Round-robin among full slots, starting one past last_idx
  always_comb begin
    rr_any = 1'b0;
    rr_idx = '0;
    for (int k = N; k >= 1; k--) begin
      int unsigned j;
      j = (int'(last_idx) + k) % N;
      if (full_vec[j]) begin
        rr_any = 1'b1;
        rr_idx = SW'(j);
      end
    end
  end
endmodule

// File: rtl/hb_slot_status.sv
module hb_slot_status #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic         stray_rel,
  output logic [N-1:0] status,
  output logic         all_full,
  output logic         all_empty,
  output logic         err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      err    <= 1'b0;
    end else begin
      status <= (status | set_vec) & ~clr_vec;
      err    <= (|(set_vec & clr_vec)) | stray_rel;
    end
  end

  assign all_full  = &status;
  assign all_empty = ~|status;
endmodule

// File: rtl/hdr_slot_buf.sv
module hdr_slot_buf
  import hb_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = HB_SLOTS_DEF,
  parameter int unsigned NUM_REGS  = HB_REGS_DEF,
  parameter int unsigned WORD_W    = HB_WORD_DEF,
  parameter int unsigned ID_W      = HB_ID_DEF,
  localparam int unsigned SW    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int unsigned RAW   = $clog2(NUM_REGS),
  localparam int unsigned DEPTH = NUM_SLOTS * NUM_REGS,
  localparam int unsigned MAW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [RAW-1:0]    wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_last,
  input  logic [ID_W-1:0]   wr_pkt_id,
  output logic [SW-1:0]     wr_slot,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [SW-1:0]     rd_slot,
  output logic [ID_W-1:0]   rd_pkt_id,
  input  logic              rd_en,
  input  logic [RAW-1:0]    rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic              rd_release,
  output logic              buf_full,
  output logic              buf_empty,
  output logic              proto_err
);
  logic [NUM_SLOTS-1:0] status, set_vec, clr_vec;
  logic                 wr_busy_q, rd_busy_q;
  logic [SW-1:0]        wr_slot_q, rd_cur_q, last_q;
  logic [SW-1:0]        lf_idx, rr_idx, wr_tgt;
  logic                 lf_any, rr_any, wr_fire, rel_ok, stray;
  logic [ID_W-1:0]      id_q [NUM_SLOTS];

  hb_slot_pick #(.N(NUM_SLOTS)) u_pick (
    .free_vec(~status), .full_vec(status), .last_idx(last_q),
    .lf_idx(lf_idx), .lf_any(lf_any), .rr_idx(rr_idx), .rr_any(rr_any)
  );

  // Writer side: a started record keeps its slot until the final word
  assign wr_tgt   = wr_busy_q ? wr_slot_q : lf_idx;
  assign wr_slot  = wr_tgt;
  assign wr_ready = wr_busy_q | lf_any;
  assign wr_fire  = wr_valid & wr_ready;
  assign set_vec  = (wr_fire && wr_last) ? (NUM_SLOTS'(1) << wr_tgt) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_busy_q <= 1'b0;
      wr_slot_q <= '0;
    end else if (wr_fire) begin
      wr_busy_q <= ~wr_last;
      wr_slot_q <= wr_tgt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SLOTS; s++) id_q[s] <= '0;
    end else if (wr_fire && wr_last) begin
      id_q[wr_tgt] <= wr_pkt_id;
    end
  end

  // Reader side: offer, claim, release
  assign rd_valid  = ~rd_busy_q & rr_any;
  assign rd_slot   = rr_idx;
  assign rd_pkt_id = id_q[rr_idx];
  assign rel_ok    = rd_release & rd_busy_q;
  assign stray     = rd_release & ~rd_busy_q;
  assign clr_vec   = rel_ok ? (NUM_SLOTS'(1) << rd_cur_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_busy_q <= 1'b0;
      rd_cur_q  <= '0;
      last_q    <= SW'(NUM_SLOTS - 1);
    end else if (rd_valid && rd_ready) begin
      rd_busy_q <= 1'b1;
      rd_cur_q  <= rr_idx;
    end else if (rel_ok) begin
      rd_busy_q <= 1'b0;
      last_q    <= rd_cur_q;
    end
  end

  hb_slot_status #(.N(NUM_SLOTS)) u_status (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .stray_rel(stray), .status(status), .all_full(buf_full),
    .all_empty(buf_empty), .err(proto_err)
  );

  hb_dpram #(.DEPTH(DEPTH), .W(WORD_W)) u_ram (
    .clk(clk),
    .we(wr_fire),
    .waddr(MAW'(wr_tgt) * MAW'(NUM_REGS) + MAW'(wr_addr)),
    .wdata(wr_data),
    .re(rd_en & rd_busy_q),
    .raddr(MAW'(rd_cur_q) * MAW'(NUM_REGS) + MAW'(rd_addr)),
    .rdata(rd_data)
  );
endmodule

// File: rtl/hb_chk.sv
module hb_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic wr_ready,
  input logic wr_last,
  input logic rd_valid,
  input logic rd_ready,
  input logic rd_release,
  input logic buf_full,
  input logic buf_empty,
  input logic proto_err
);
  // R9
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_full && buf_empty));

  // R4
  full_blocks_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !wr_ready);

  // R3
  set_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_full) |-> $past(wr_valid && wr_ready && wr_last));

  // R8
  full_drop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_full) |-> $past(rd_release));

  // R5
  hold_blocks_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> !rd_valid);

  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(rd_release || wr_valid));
endmodule

bind hdr_slot_buf hb_chk u_hb_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_last(wr_last), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_release(rd_release), .buf_full(buf_full), .buf_empty(buf_empty),
  .proto_err(proto_err)
);

// File: tb/tb_hdr_slot_buf.sv
module tb_hdr_slot_buf;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, wr_last = 1'b0;
  logic        wr_ready;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [11:0] wr_pkt_id = '0;
  logic [1:0]  wr_slot, rd_slot;
  logic        rd_valid, rd_ready = 1'b0, rd_en = 1'b0, rd_release = 1'b0;
  logic [11:0] rd_pkt_id;
  logic [4:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        buf_full, buf_empty, proto_err;

  int checks = 0, fails = 0;
  logic [15:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hdr_slot_buf dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_last(wr_last),
    .wr_pkt_id(wr_pkt_id), .wr_slot(wr_slot), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_slot(rd_slot), .rd_pkt_id(rd_pkt_id),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_release(rd_release), .buf_full(buf_full), .buf_empty(buf_empty),
    .proto_err(proto_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] wordv(input logic [7:0] tag, input int r);
    return {tag, 8'(r)};
  endfunction

  // Monitor: a read strobed at an edge returns data after that edge (R6)
  always @(posedge clk) begin
    logic took;
    took = rd_en;
    #2;
    if (took) begin
      if (exp_q.size() == 0) check("R6 unexpected read", 32'(rd_data), 32'hDEAD);
      else check("R6 read data", 32'(rd_data), 32'(exp_q.pop_front()));
    end
  end

  task automatic write_record(input logic [7:0] tag, input logic [11:0] id,
                              input logic [1:0] exp_slot, input bit chk_hidden);
    for (int r = 0; r < 32; r++) begin
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = 5'(r); wr_data = wordv(tag, r);
      wr_last = (r == 31); wr_pkt_id = id;
      if (r == 0) check("R2 slot choice", 32'(wr_slot), 32'(exp_slot));
      if (chk_hidden && (r == 16 || r == 31)) check("R3 no offer mid-record", 32'(rd_valid), 0);
    end
    @(negedge clk);
    wr_valid = 1'b0; wr_last = 1'b0;
  endtask

  task automatic read_words(input logic [7:0] tag, input int a, input int b, input int c);
    int idx [3];
    idx = '{a, b, c};
    foreach (idx[i]) begin
      @(negedge clk);
      rd_en = 1'b1; rd_addr = 5'(idx[i]);
      exp_q.push_back(wordv(tag, idx[i]));
    end
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic acquire(input logic [1:0] exp_slot, input logic [11:0] exp_id);
    check("R5 offer valid", 32'(rd_valid), 1);
    check("R5 round-robin slot", 32'(rd_slot), 32'(exp_slot));
    check("R7 packet id", 32'(rd_pkt_id), 32'(exp_id));
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    check("R5 no offer while held", 32'(rd_valid), 0);
  endtask

  task automatic release_slot();
    rd_release = 1'b1;
    @(negedge clk);
    rd_release = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 empty", 32'(buf_empty), 1);
    check("R1 full", 32'(buf_full), 0);
    check("R1 wr_ready", 32'(wr_ready), 1);
    check("R1 rd_valid", 32'(rd_valid), 0);
    check("R1 proto_err", 32'(proto_err), 0);
    check("R1 wr_slot", 32'(wr_slot), 0);

    write_record(8'hA0, 12'd1, 2'd0, 1'b1);
    check("R3 offer after last", 32'(rd_valid), 1);
    check("R9 not empty", 32'(buf_empty), 0);
    write_record(8'hB1, 12'd2, 2'd1, 1'b0);
    write_record(8'hC2, 12'd3, 2'd2, 1'b0);
    write_record(8'hD3, 12'd4, 2'd3, 1'b0);
    check("R9 full", 32'(buf_full), 1);
    check("R4 writer stalled", 32'(wr_ready), 0);

    acquire(2'd0, 12'd1);
    read_words(8'hA0, 0, 5, 31);
    release_slot();
    check("R8 bit cleared", 32'(buf_full), 0);
    check("R8 writer ready", 32'(wr_ready), 1);
    check("R8 freed slot reused", 32'(wr_slot), 0);
    check("R0 no error", 32'(proto_err), 0);

    acquire(2'd1, 12'd2);
    fork
      write_record(8'hE4, 12'd5, 2'd0, 1'b0);
      begin
        read_words(8'hB1, 3, 30, 17);
        read_words(8'hB1, 0, 1, 2);
      end
    join
    release_slot();
    acquire(2'd2, 12'd3);
    read_words(8'hC2, 9, 10, 11);
    release_slot();
    acquire(2'd3, 12'd4);
    release_slot();
    acquire(2'd0, 12'd5);
    read_words(8'hE4, 7, 31, 0);
    release_slot();
    check("R9 empty again", 32'(buf_empty), 1);
    check("R5 nothing offered", 32'(rd_valid), 0);

    release_slot();
    check("R10 stray release flagged", 32'(proto_err), 1);
    check("R10 bits unchanged", 32'(buf_empty), 1);
    @(negedge clk);
    check("R10 one-cycle flag", 32'(proto_err), 0);
    check("R6 all reads returned", 32'(exp_q.size()), 0);
    summary();
  end
endmodule